// File: doc/BRIEF.md
# Host-Clocked Serial Score Readout

This block sits between a compute core that produces ten signed 8-bit class scores and a slow host that reaches the fabric only through a few general-purpose signals. The host starts a computation by raising a start line, waits for a completion flag, and then pulls the scores out one byte at a time. It does this by raising a select line and toggling a software clock. Every rising edge of that clock loads the next score onto an 8-bit data port. The read position returns to the first score whenever select is dropped.

The host signals are not related to the fabric clock. Each one passes through a two-flop synchronizer, and edges are found in the fabric domain. When the core reports completion, the score array is copied into a holding register. A readout therefore always sees a stable snapshot, even if the core's outputs move afterwards.

Top module: `score_readout`

## Requirements
- R1: After reset, `host_done` is 0, `host_data` is 0 and `core_start` is 0.
- R2: A low-to-high change on `host_start` gives exactly one single-cycle `core_start` pulse and drives `host_done` to 0. Holding `host_start` high gives no further pulses.
- R3: A `core_done` pulse while a computation is running sets `host_done` to 1. The flag stays at 1 until the next rising edge on `host_start`.
- R4: A `core_done` pulse while no computation is running has no effect: `host_done` keeps its value and the scores read out stay the same.
- R5: At completion the block captures `core_result`, with score i taken from bits [8*i+7 : 8*i]. A later change on `core_result` does not change what is read out.
- R6: While `host_cs` is low, the read position is held at score 0. After select is dropped and raised again, the first clock pulse returns score 0.
- R7: While `host_cs` is high, each rising edge of `host_sclk` loads the score at the current position onto `host_data` and then advances the position. Ten pulses return scores 0 to 9 in order.
- R8: Once score 9 has been loaded, further `host_sclk` rising edges keep returning score 9. The position does not wrap.
- R9: A `host_sclk` rising edge while `host_cs` is low leaves `host_data` unchanged.
- R10: `host_data` shows the new score no more than 4 fabric clock cycles after the `host_sclk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sclk | input | 1 | Host software clock, asynchronous |
| host_cs | input | 1 | Host select, asynchronous; low resets the read position |
| host_start | input | 1 | Host start request, asynchronous; a rising edge restarts the computation |
| host_data | output | 8 | Score loaded by the last accepted clock edge |
| host_done | output | 1 | High once the current computation has finished |
| core_start | output | 1 | Single-cycle pulse that launches the compute core |
| core_done | input | 1 | Single-cycle pulse from the core: its result is final |
| core_result | input | 80 | Ten packed 8-bit scores, score i in bits [8*i+7 : 8*i] |

## Verification
The hardest case to reach is a completion pulse that arrives when no computation is running, either before any start or after a result has already been captured. In that case the holding register must not move. The only way to see this from the ports is to read the scores again. The bench therefore fires `core_done` with a second, distinct pattern in both the idle and finished states, checks that `host_done` has not changed, and then reads back through the select and clock sequence to show that the first pattern is still there. A later restart with that second pattern confirms that the capture path itself still works.

// File: rtl/score_readout_pkg.sv
package score_readout_pkg;

    parameter int NUM_SCORES  = 10;
    parameter int SCORE_W     = 8;
    parameter int SYNC_DEPTH  = 2;

    typedef struct packed {
        logic sclk;
        logic cs;
        logic start;
    } host_lines_t;

    localparam int HOST_LINES = $bits(host_lines_t);

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_BUSY = 2'd1,
        RUN_DONE = 2'd2
    } run_state_t;

    function automatic int unsigned step_pos(int unsigned pos, int unsigned last);
        return (pos >= last) ? last : pos + 1;
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] last_level;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign level[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) last_level <= '0;
        else     last_level <= level;
    end

    assign rise = level & ~last_level;

    for (genvar g = 0; g < W; g++) begin : g_chk
        p_edge_single_r2: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/run_control.sv
module run_control
    import score_readout_pkg::*;
#(
    parameter int N = NUM_SCORES,
    parameter int W = SCORE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_rise,
    input  logic         core_done,
    input  logic [N*W-1:0] core_result,
    output logic         core_start,
    output logic         done,
    output logic [N*W-1:0] held
);
    run_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RUN_IDLE;
            core_start <= 1'b0;
            held       <= '0;
        end else begin
            core_start <= start_rise;
            if (start_rise) begin
                state <= RUN_BUSY;
            end else if (state == RUN_BUSY && core_done) begin
                state <= RUN_DONE;
                held  <= core_result;
            end
        end
    end

    assign done = (state == RUN_DONE);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        start_rise |=> (!done && core_start));
    p_pulse_short_r2: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);
    p_done_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(core_done));
    p_idle_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (core_done && state != RUN_BUSY && !start_rise) |=> $stable(done));
    p_held_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !(state == RUN_BUSY && core_done) |=> $stable(held));
endmodule

// File: rtl/score_shifter.sv
module score_shifter
    import score_readout_pkg::*;
#(
    parameter int N = NUM_SCORES,
    parameter int W = SCORE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs,
    input  logic           sclk_rise,
    input  logic [N*W-1:0] held,
    output logic [W-1:0]   data
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned LAST = N - 1;

    logic [PW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            data <= '0;
        end else if (!cs) begin
            pos <= '0;
        end else if (sclk_rise) begin
            data <= held[pos*W +: W];
            pos  <= PW'(step_pos(int'(pos), LAST));
        end
    end

    p_pos_range_r8: assert property (@(posedge clk) disable iff (rst)
        int'(pos) <= LAST);
    p_cs_home_r6: assert property (@(posedge clk) disable iff (rst)
        !cs |=> pos == '0);
    p_data_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!sclk_rise || !cs) |=> $stable(data));
endmodule

// File: rtl/score_readout.sv
module score_readout
    import score_readout_pkg::*;
#(
    parameter int N      = NUM_SCORES,
    parameter int W      = SCORE_W,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_sclk,
    input  logic           host_cs,
    input  logic           host_start,
    output logic [W-1:0]   host_data,
    output logic           host_done,
    output logic           core_start,
    input  logic           core_done,
    input  logic [N*W-1:0] core_result
);
    host_lines_t raw_lines, sync_level, sync_rise;
    logic [N*W-1:0] held;

    assign raw_lines = '{sclk: host_sclk, cs: host_cs, start: host_start};

    line_sync #(.W(HOST_LINES), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_lines),
        .level (sync_level),
        .rise  (sync_rise)
    );

    run_control #(.N(N), .W(W)) u_run (
        .clk         (clk),
        .rst         (rst),
        .start_rise  (sync_rise.start),
        .core_done   (core_done),
        .core_result (core_result),
        .core_start  (core_start),
        .done        (host_done),
        .held        (held)
    );

    score_shifter #(.N(N), .W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs        (sync_level.cs),
        .sclk_rise (sync_rise.sclk),
        .held      (held),
        .data      (host_data)
    );
endmodule

// File: tb/score_readout_test.sv
module score_readout_test;
    localparam int N = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_sclk = 1'b0, host_cs = 1'b0, host_start = 1'b0;
    logic core_done = 1'b0;
    logic [N*W-1:0] core_result = '0;
    logic [W-1:0] host_data;
    logic host_done, core_start;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    score_readout uut (
        .clk(clk), .rst(rst),
        .host_sclk(host_sclk), .host_cs(host_cs), .host_start(host_start),
        .host_data(host_data), .host_done(host_done),
        .core_start(core_start), .core_done(core_done), .core_result(core_result)
    );

    function automatic logic [W-1:0] pat_a(int i);
        return W'(i * 17 + 3);
    endfunction
    function automatic logic [W-1:0] pat_b(int i);
        return W'(8'hF0 - i * 13);
    endfunction
    function automatic logic [N*W-1:0] pack(bit use_b);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = use_b ? pat_b(i) : pat_a(i);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(logic v);
        @(negedge clk) host_cs = v;
        wait_n(4);
    endtask

    task automatic pulse_sclk(output logic [W-1:0] got);
        @(negedge clk) host_sclk = 1'b1;
        wait_n(4);
        got = host_data;
        host_sclk = 1'b0;
        wait_n(4);
    endtask

    task automatic pulse_done(bit use_b);
        @(negedge clk) begin core_done = 1'b1; core_result = pack(use_b); end
        @(negedge clk) core_done = 1'b0;
        wait_n(1);
    endtask

    task automatic t_reset;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        chk("R1 done", 32'(host_done), 0);
        chk("R1 data", 32'(host_data), 0);
        chk("R1 core_start", 32'(core_start), 0);
    endtask

    task automatic t_idle_done_ignored;
        logic [W-1:0] d;
        pulse_done(1'b1);
        chk("R4 idle done flag", 32'(host_done), 0);
        set_cs(1'b1);
        pulse_sclk(d);
        chk("R4 idle hold untouched", 32'(d), 0);
        set_cs(1'b0);
    endtask

    task automatic t_start;
        int pulses = 0;
        @(negedge clk) host_start = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (core_start) pulses++;
        end
        chk("R2 one pulse", 32'(pulses), 1);
        chk("R2 done cleared", 32'(host_done), 0);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (core_start) pulses++;
        end
        chk("R2 no repeat while high", 32'(pulses), 0);
        @(negedge clk) host_start = 1'b0;
        wait_n(4);
    endtask

    task automatic t_complete(bit use_b);
        pulse_done(use_b);
        chk("R3 done set", 32'(host_done), 1);
        @(negedge clk) core_result = pack(!use_b);
        wait_n(2);
        chk("R3 done held", 32'(host_done), 1);
    endtask

    task automatic t_read_all(bit use_b);
        logic [W-1:0] d;
        set_cs(1'b1);
        for (int i = 0; i < N; i++) begin
            pulse_sclk(d);
            chk(use_b ? "R7 R5 R10 score B" : "R7 R5 R10 score A", 32'(d),
                32'(use_b ? pat_b(i) : pat_a(i)));
        end
    endtask

    task automatic t_overrun;
        logic [W-1:0] d;
        for (int i = 0; i < 2; i++) begin
            pulse_sclk(d);
            chk("R8 stays at last", 32'(d), 32'(pat_a(N-1)));
        end
    endtask

    task automatic t_sclk_no_cs;
        logic [W-1:0] d;
        set_cs(1'b0);
        for (int i = 0; i < 2; i++) begin
            pulse_sclk(d);
            chk("R9 data frozen", 32'(d), 32'(pat_a(N-1)));
        end
    endtask

    task automatic t_cs_home;
        logic [W-1:0] d;
        set_cs(1'b1);
        pulse_sclk(d);
        chk("R6 first", 32'(d), 32'(pat_a(0)));
        pulse_sclk(d);
        chk("R6 second", 32'(d), 32'(pat_a(1)));
        set_cs(1'b0);
        set_cs(1'b1);
        pulse_sclk(d);
        chk("R6 back to zero", 32'(d), 32'(pat_a(0)));
        set_cs(1'b0);
    endtask

    task automatic t_done_after_done;
        logic [W-1:0] d;
        pulse_done(1'b1);
        chk("R4 done unchanged", 32'(host_done), 1);
        set_cs(1'b1);
        pulse_sclk(d);
        chk("R4 hold kept A", 32'(d), 32'(pat_a(0)));
        set_cs(1'b0);
    endtask

    task automatic t_restart;
        t_start();
        t_complete(1'b1);
        t_read_all(1'b1);
        set_cs(1'b0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_done_ignored();
        t_start();
        t_complete(1'b0);
        t_read_all(1'b0);
        t_overrun();
        t_sclk_no_cs();
        t_cs_home();
        t_done_after_done();
        t_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule